// File: doc/BRIEF.md
# Narrow-to-wide registered bus exchanger

The block connects a narrow data port A of `NW` bits to a wide port B of `2*NW` bits. Port B is split into a lower half (1B, bits `NW-1:0`) and an upper half (2B, bits `2*NW-1:NW`). In the narrow-to-wide direction, two narrow words that arrive on consecutive clock edges are captured. They are then presented together as one wide word. The path into 1B is a two-stage pipeline and the path into 2B is a single register, so the earlier word lands in 1B and the later word lands in 2B.

In the wide-to-narrow direction, each half of B has its own capture register. A registered select picks which stored half drives the A outputs. Every register captures only on a rising edge, and only while its own active-low clock enable is low. The output enables for both ports are also registered, so a change of bus direction happens only at a clock edge. Each port is modelled as a separate input bus, output bus and output-enable flag rather than as a tri-state pin. A synchronous reset puts both output enables in the disabled state.

Top module: `bus_widener`

## Requirements
- R1: While `rst` is high at a rising edge, both output-enable registers are loaded with the disabled state. `a_oe` and `b_oe` read 0 after that edge, whatever `oea_n` and `oeb_n` are.
- R2: After each rising edge outside reset, `a_oe` equals the inverse of `oea_n` and `b_oe` equals the inverse of `oeb_n`, both as sampled at that edge. A change of `oea_n` or `oeb_n` between edges leaves both flags unchanged until the next edge.
- R3: Word W0 is applied with `cke_a1_n`=0 and `cke_a2_n`=1. Word W1 is applied at the next edge with both enables 0. After that second edge, `b_out[NW-1:0]` is W0 and `b_out[2*NW-1:NW]` is W1.
- R4: While `cke_a1_n` is 1, both stages of the 1B pipeline hold their contents. `b_out[NW-1:0]` does not change. The first advance afterwards shows the word that was held in the first stage, not any word applied while the pipeline was held.
- R5: The 2B register loads `a_in` at an edge where `cke_a2_n` is 0. While `cke_a2_n` is 1, `b_out[2*NW-1:NW]` does not change.
- R6: The B1-to-A register loads `b_in[NW-1:0]` at an edge where `cke_b1_n` is 0, and the B2-to-A register loads `b_in[2*NW-1:NW]` at an edge where `cke_b2_n` is 0. Each register holds while its enable is 1.
- R7: `sel_n` is sampled at each rising edge. A sampled 0 drives the stored 1B data onto `a_out`, and a sampled 1 drives the stored 2B data. A change of `sel_n` between edges does not alter `a_out` before the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, disables both outputs |
| a_in | input | NW | Narrow port input data |
| b_in | input | 2*NW | Wide port input data (1B low half, 2B high half) |
| cke_a1_n | input | 1 | Active-low clock enable of the A-to-1B pipeline |
| cke_a2_n | input | 1 | Active-low clock enable of the A-to-2B register |
| cke_b1_n | input | 1 | Active-low clock enable of the 1B-to-A register |
| cke_b2_n | input | 1 | Active-low clock enable of the 2B-to-A register |
| sel_n | input | 1 | Select: 0 picks stored 1B, 1 picks stored 2B for A |
| oea_n | input | 1 | Active-low A-side output enable request |
| oeb_n | input | 1 | Active-low B-side output enable request |
| a_out | output | NW | Narrow port output data |
| a_oe | output | 1 | A outputs driven when 1 |
| b_out | output | 2*NW | Wide port output data |
| b_oe | output | 1 | B outputs driven when 1 |

## Verification
The bench builds the block with its default `NW` of 12. This gives a 24-bit wide word whose halves carry distinct, recognisable patterns. A swap of the halves, or a word taken one edge early or late, therefore shows as a mismatch. The word table is chosen so that each pair differs in both halves and across pairs. Held words are replaced on `a_in` and `b_in` by fresh values, so any capture that should not happen becomes visible at the outputs.

// File: rtl/bus_widener.sv
module bus_widener #(
  parameter int NW = 12,
  localparam int WW = 2 * NW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NW-1:0] a_in,
  input  logic [WW-1:0] b_in,
  input  logic          cke_a1_n,
  input  logic          cke_a2_n,
  input  logic          cke_b1_n,
  input  logic          cke_b2_n,
  input  logic          sel_n,
  input  logic          oea_n,
  input  logic          oeb_n,
  output logic [NW-1:0] a_out,
  output logic          a_oe,
  output logic [WW-1:0] b_out,
  output logic          b_oe
);

  logic [NW-1:0] a1_s1, a1_s2, a2_r, b1_r, b2_r;
  logic          sel_q, oea_q, oeb_q;

  always_ff @(posedge clk) begin
    if (!cke_a1_n) begin
      a1_s1 <= a_in;
      a1_s2 <= a1_s1;
    end
    if (!cke_a2_n) a2_r <= a_in;
    if (!cke_b1_n) b1_r <= b_in[NW-1:0];
    if (!cke_b2_n) b2_r <= b_in[WW-1:NW];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oea_q <= 1'b1;
      oeb_q <= 1'b1;
      sel_q <= 1'b1;
    end else begin
      oea_q <= oea_n;
      oeb_q <= oeb_n;
      sel_q <= sel_n;
    end
  end

  assign b_out = {a2_r, a1_s2};
  assign a_out = sel_q ? b2_r : b1_r;
  assign a_oe  = ~oea_q;
  assign b_oe  = ~oeb_q;

endmodule

module bus_widener_chk #(
  parameter int NW = 12,
  localparam int WW = 2 * NW
) (
  input logic          clk,
  input logic          rst,
  input logic [NW-1:0] a_in,
  input logic [WW-1:0] b_in,
  input logic          cke_a1_n,
  input logic          cke_a2_n,
  input logic          cke_b1_n,
  input logic          cke_b2_n,
  input logic          sel_n,
  input logic          oea_n,
  input logic          oeb_n,
  input logic [NW-1:0] a_out,
  input logic          a_oe,
  input logic [WW-1:0] b_out,
  input logic          b_oe
);

  a_r1_reset_disables: assert property (@(posedge clk) rst |=> (!a_oe && !b_oe));

  a_r2_oe_registered: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (a_oe == !$past(oea_n) && b_oe == !$past(oeb_n)));

  a_r3_pair_order: assert property (@(posedge clk) disable iff (rst)
    (!cke_a1_n && !cke_a2_n && $past(!cke_a1_n))
    |=> (b_out[NW-1:0] == $past(a_in, 2) && b_out[WW-1:NW] == $past(a_in)));

  a_r4_pipe_hold: assert property (@(posedge clk) disable iff (rst)
    cke_a1_n |=> $stable(b_out[NW-1:0]));

  a_r5_wide_hold: assert property (@(posedge clk) disable iff (rst)
    cke_a2_n |=> $stable(b_out[WW-1:NW]));

  a_r7_select_lo: assert property (@(posedge clk) disable iff (rst)
    (!sel_n && !cke_b1_n) |=> (a_out == $past(b_in[NW-1:0])));

  a_r7_select_hi: assert property (@(posedge clk) disable iff (rst)
    (sel_n && !cke_b2_n) |=> (a_out == $past(b_in[WW-1:NW])));

endmodule

bind bus_widener bus_widener_chk #(.NW(NW)) u_chk (.*);

// File: tb/bus_widener_test.sv
module bus_widener_test;
  localparam int NW = 12;
  localparam int WW = 2 * NW;
  localparam int NP = 4;
  localparam logic [NW-1:0] WORDS [2*NP] = '{
    12'hA5C, 12'h3E1, 12'h0F0, 12'hFFF, 12'h123, 12'hBAD, 12'h800, 12'h001
  };

  logic clk = 1'b0;
  logic rst;
  logic [NW-1:0] a_in;
  logic [WW-1:0] b_in;
  logic cke_a1_n, cke_a2_n, cke_b1_n, cke_b2_n, sel_n, oea_n, oeb_n;
  logic [NW-1:0] a_out;
  logic [WW-1:0] b_out;
  logic a_oe, b_oe;
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  bus_widener #(.NW(NW)) uut (.*);

  task automatic chk(input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst = 1'b1; a_in = '0; b_in = '0;
    cke_a1_n = 1'b1; cke_a2_n = 1'b1; cke_b1_n = 1'b1; cke_b2_n = 1'b1;
    sel_n = 1'b1; oea_n = 1'b0; oeb_n = 1'b0;
    cyc(); cyc();
    // R1: reset overrides requested enables
    chk("R1 a_oe", a_oe, 0);
    chk("R1 b_oe", b_oe, 0);
    rst = 1'b0;
    #1;
    chk("R1 before edge b_oe", b_oe, 0);
    cyc();
    chk("R2 a_oe on", a_oe, 1);
    chk("R2 b_oe on", b_oe, 1);

    // R3: stream word pairs from the table
    for (int p = 0; p < NP; p++) begin
      a_in = WORDS[2*p]; cke_a1_n = 1'b0; cke_a2_n = 1'b1;
      cyc();
      a_in = WORDS[2*p+1]; cke_a1_n = 1'b0; cke_a2_n = 1'b0;
      cyc();
      cke_a1_n = 1'b1; cke_a2_n = 1'b1; a_in = ~WORDS[2*p];
      chk("R3 pair", b_out, {WORDS[2*p+1], WORDS[2*p]});
      cyc();
      chk("R3 pair held", b_out, {WORDS[2*p+1], WORDS[2*p]});
    end

    // R4/R5: hold with changing inputs, then one advance
    // first stage holds WORDS[7], output holds {WORDS[7],WORDS[6]}
    for (int k = 0; k < 3; k++) begin
      a_in = 12'h5A0 + 12'(k);
      cyc();
      chk("R4 lo held", b_out[NW-1:0], WORDS[6]);
      chk("R5 hi held", b_out[WW-1:NW], WORDS[7]);
    end
    a_in = 12'h777; cke_a1_n = 1'b0;
    cyc();
    cke_a1_n = 1'b1;
    chk("R4 advance shows held stage", b_out[NW-1:0], WORDS[7]);
    chk("R5 hi unaffected", b_out[WW-1:NW], WORDS[7]);
    a_in = 12'h999; cke_a2_n = 1'b0;
    cyc();
    cke_a2_n = 1'b1;
    chk("R5 load", b_out[WW-1:NW], 12'h999);

    // R6/R7: wide-to-narrow capture and select
    b_in = {12'hC33, 12'h4D2}; cke_b1_n = 1'b0; cke_b2_n = 1'b0; sel_n = 1'b0;
    cyc();
    cke_b1_n = 1'b1; cke_b2_n = 1'b1; b_in = {12'h111, 12'h222};
    chk("R7 sel 1B", a_out, 12'h4D2);
    sel_n = 1'b1;
    #1;
    chk("R7 sel registered", a_out, 12'h4D2);
    cyc();
    chk("R7 sel 2B", a_out, 12'hC33);
    sel_n = 1'b0;
    cyc();
    chk("R6 1B held", a_out, 12'h4D2);
    b_in = {12'h6E6, 12'h0AB}; cke_b1_n = 1'b0;
    cyc();
    cke_b1_n = 1'b1;
    chk("R6 1B load", a_out, 12'h0AB);
    sel_n = 1'b1;
    cyc();
    chk("R6 2B held", a_out, 12'hC33);

    // R2: direction change only at the edge
    oea_n = 1'b1; oeb_n = 1'b1;
    #1;
    chk("R2 a_oe unchanged", a_oe, 1);
    chk("R2 b_oe unchanged", b_oe, 1);
    cyc();
    chk("R2 a_oe off", a_oe, 0);
    chk("R2 b_oe off", b_oe, 0);
    oea_n = 1'b0;
    cyc();
    chk("R2 a_oe on only A", a_oe, 1);
    chk("R2 b_oe stays off", b_oe, 0);

    // R1: reset mid-run
    oeb_n = 1'b0; rst = 1'b1;
    cyc();
    chk("R1 a_oe mid", a_oe, 0);
    chk("R1 b_oe mid", b_oe, 0);
    rst = 1'b0;
    cyc();
    summary();
  end
endmodule